// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block resolves a virtual page number into a physical page number by reading a hierarchical page table out of memory. It sits behind a TLB. On a miss the TLB hands over the virtual page number and an access-type bit. The walker then reads one page table entry per level, starting at the root table named by the translation-control value. It returns either the translated leaf or a fault.

The walk depth, the index width and the entry size depend on the translation mode. The mode and the root are taken from the control inputs at the moment a request is accepted. Entries are read through a plain read master with a valid/ready request side and a valid response side. The response side can flag a bus error. A leaf whose accessed bit is clear, or whose dirty bit is clear on a store, is reported as a page fault. The walker never writes those bits back.

Only one walk is in flight at a time. The result stays on the response port until the TLB takes it.

Top module: `pt_walker`

## Requirements
- R1: A request is accepted when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from the cycle after acceptance until the response has been taken with `rsp_ready_i`. While `rsp_valid_o` waits for `rsp_ready_i`, every response field stays unchanged.
- R2: Mode code 0 (no translation), and any code not listed in R3, answers with `rsp_valid_o` and `rsp_page_fault_o` high in the cycle after acceptance. No memory read is issued.
- R3: Each mode code fixes the walk shape:
  - code 1: 2 levels, 10-bit indices, 4-byte entries, with the entry in data bits 31:0.
  - code 8: 3 levels, 9-bit indices, 8-byte entries.
  - code 9: 4 levels, 9-bit indices, 8-byte entries.
  - code 10: 5 levels, 9-bit indices, 8-byte entries.
  
  The walk starts at the highest level and counts down to level 0. The index for level L is VPN bits [L*w +: w], where w is the index width.
- R4: Each read address is the table PPN times 4096 plus the level index times the entry size. The first table is the root PPN. The entry's PPN field starts at bit 10: 22 bits wide in code 1, 44 bits wide otherwise. Flag bits are V=0, R=1, W=2, X=3, A=6, D=7. The address is held stable while the read is not accepted.
- R5: An entry with V clear, or with W set and R clear, ends the walk with a page fault.
- R6: An entry with R, W and X all clear points to the next table, and the walk descends one level. Such an entry at level 0 ends the walk with a page fault.
- R7: A leaf found at level L above 0 must have its low L index-widths of PPN equal to zero, or a page fault results. If they are zero, the returned PPN takes those low bits from the VPN. `rsp_level_o` reports L.
- R8: A leaf with A clear is a page fault. A leaf with D clear is a page fault for a store and is accepted for a load.
- R9: A read answered with `mem_rsp_err_i` ends the walk with `rsp_access_fault_o` high and `rsp_page_fault_o` low. The two fault outputs are never high together.
- R10: A good leaf returns its PPN, its low 8 entry bits on `rsp_flags_o` and its level, with both fault outputs low.
- R11: Mode and root are sampled only at acceptance. Changes to them during a walk do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Translation mode code |
| root_ppn_i | input | PPN_W | Root page table PPN |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vpn_i | input | VPN_W | Virtual page number to resolve |
| req_store_i | input | 1 | Request is for a store access |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Requester takes the result |
| rsp_ppn_o | output | PPN_W | Translated PPN (zero on fault) |
| rsp_flags_o | output | 8 | Low byte of the leaf entry |
| rsp_level_o | output | LVL_W | Level at which the walk ended |
| rsp_page_fault_o | output | 1 | Page fault |
| rsp_access_fault_o | output | 1 | Bus error during the walk |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory takes the read |
| mem_addr_o | output | PA_W | Physical address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | DATA_W | Read data |
| mem_rsp_err_i | input | 1 | Read ended in a bus error |

## Verification
A wrong level counter or index split shows up as a read at an unexpected address. Against a sparse memory image this gives a zero entry and a page fault, or a read count that differs from the level count. Either is visible as soon as the walk's response appears. A bad mode decode shows in the first read address, or in a missing immediate fault for the no-translation mode one cycle after acceptance. A misrouted superpage mask or flag decode shows in the returned PPN or fault bit of the affected leaf. The vector table therefore covers every leaf level in every mode.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int PW_VPN_W     = 45;
    localparam int PW_PPN_W     = 44;
    localparam int PW_PG_SHIFT  = 12;
    localparam int PW_DATA_W    = 64;
    localparam int PW_LVL_W     = 3;
    localparam int PW_MAX_LVLS  = 5;

    localparam int IDX_W_SHORT  = 10;
    localparam int IDX_W_WIDE   = 9;
    localparam int PTE_SH_SHORT = 2;
    localparam int PTE_SH_WIDE  = 3;
    localparam int PPN_W_SHORT  = 22;
    localparam int PTE_PPN_LSB  = 10;

    localparam int FL_V = 0;
    localparam int FL_R = 1;
    localparam int FL_W = 2;
    localparam int FL_X = 3;
    localparam int FL_A = 6;
    localparam int FL_D = 7;

    localparam logic [3:0] MC_BARE = 4'd0;
    localparam logic [3:0] MC_L2   = 4'd1;
    localparam logic [3:0] MC_L3   = 4'd8;
    localparam logic [3:0] MC_L4   = 4'd9;
    localparam logic [3:0] MC_L5   = 4'd10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MREQ  = 2'd1,
        ST_MWAIT = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        PTE_BAD      = 2'd0,
        PTE_PTR      = 2'd1,
        PTE_LEAF     = 2'd2,
        PTE_LEAF_FLT = 2'd3
    } pte_kind_e;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int VPN_W    = PW_VPN_W,
    parameter int PPN_W    = PW_PPN_W,
    parameter int LVL_W    = PW_LVL_W,
    parameter int PG_SHIFT = PW_PG_SHIFT,
    localparam int PA_W    = PPN_W + PG_SHIFT
) (
    input  logic             short_fmt_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [VPN_W-1:0] vpn_i,
    input  logic [PPN_W-1:0] table_ppn_i,
    output logic [PA_W-1:0]  addr_o
);

    logic [IDX_W_WIDE-1:0]  idx_wide;
    logic [IDX_W_SHORT-1:0] idx_short;
    logic [PA_W-1:0]        offset;

    always_comb begin
        idx_wide  = IDX_W_WIDE'(vpn_i >> (32'(level_i) * IDX_W_WIDE));
        idx_short = IDX_W_SHORT'(vpn_i >> (32'(level_i) * IDX_W_SHORT));
        if (short_fmt_i) begin
            offset = PA_W'({idx_short, {PTE_SH_SHORT{1'b0}}});
        end else begin
            offset = PA_W'({idx_wide, {PTE_SH_WIDE{1'b0}}});
        end
        addr_o = {table_ppn_i, {PG_SHIFT{1'b0}}} + offset;
    end

endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int PPN_W    = PW_PPN_W,
    parameter int DATA_W   = PW_DATA_W,
    parameter int LVL_W    = PW_LVL_W,
    parameter int MAX_LVLS = PW_MAX_LVLS
) (
    input  logic [DATA_W-1:0] pte_i,
    input  logic              short_fmt_i,
    input  logic [LVL_W-1:0]  level_i,
    input  logic [PPN_W-1:0]  vpn_low_i,
    input  logic              store_i,
    output pte_kind_e         kind_o,
    output logic [PPN_W-1:0]  next_ppn_o,
    output logic [PPN_W-1:0]  leaf_ppn_o
);

    logic [PPN_W-1:0] mask_wide  [MAX_LVLS];
    logic [PPN_W-1:0] mask_short [MAX_LVLS];

    for (genvar l = 0; l < MAX_LVLS; l++) begin : g_mask
        assign mask_wide[l]  = ~({PPN_W{1'b1}} << (l * IDX_W_WIDE));
        assign mask_short[l] = ~({PPN_W{1'b1}} << (l * IDX_W_SHORT));
    end

    logic [PPN_W-1:0] low_mask;
    logic             misaligned;
    logic             v, r, w, x, a, d;

    logic unused_pte_bits;
    assign unused_pte_bits = ^{pte_i[DATA_W-1:PTE_PPN_LSB+PPN_W], pte_i[9:8], pte_i[5:4]};

    always_comb begin
        v = pte_i[FL_V];
        r = pte_i[FL_R];
        w = pte_i[FL_W];
        x = pte_i[FL_X];
        a = pte_i[FL_A];
        d = pte_i[FL_D];

        if (short_fmt_i) begin
            next_ppn_o = PPN_W'(pte_i[PTE_PPN_LSB +: PPN_W_SHORT]);
        end else begin
            next_ppn_o = pte_i[PTE_PPN_LSB +: PPN_W];
        end

        low_mask = '0;
        if (32'(level_i) < MAX_LVLS) begin
            low_mask = short_fmt_i ? mask_short[level_i] : mask_wide[level_i];
        end
        misaligned = |(next_ppn_o & low_mask);
        leaf_ppn_o = (next_ppn_o & ~low_mask) | (vpn_low_i & low_mask);

        if (!v || (w && !r)) begin
            kind_o = PTE_BAD;
        end else if (!r && !x) begin
            kind_o = PTE_PTR;
        end else if (misaligned || !a || (store_i && !d)) begin
            kind_o = PTE_LEAF_FLT;
        end else begin
            kind_o = PTE_LEAF;
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VPN_W    = PW_VPN_W,
    parameter int PPN_W    = PW_PPN_W,
    parameter int DATA_W   = PW_DATA_W,
    parameter int LVL_W    = PW_LVL_W,
    parameter int PG_SHIFT = PW_PG_SHIFT,
    localparam int PA_W    = PPN_W + PG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_i,
    input  logic [PPN_W-1:0]  root_ppn_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [VPN_W-1:0]  req_vpn_i,
    input  logic              req_store_i,
    output logic              rsp_valid_o,
    input  logic              rsp_ready_i,
    output logic [PPN_W-1:0]  rsp_ppn_o,
    output logic [7:0]        rsp_flags_o,
    output logic [LVL_W-1:0]  rsp_level_o,
    output logic              rsp_page_fault_o,
    output logic              rsp_access_fault_o,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [PA_W-1:0]   mem_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [DATA_W-1:0] mem_rsp_data_i,
    input  logic              mem_rsp_err_i
);

    typedef struct packed {
        walk_state_e      state;
        logic             short_fmt;
        logic [LVL_W-1:0] level;
        logic [VPN_W-1:0] vpn;
        logic             store;
        logic [PPN_W-1:0] table_ppn;
        logic [PPN_W-1:0] res_ppn;
        logic [7:0]       res_flags;
        logic             pf;
        logic             af;
    } walk_s;

    walk_s q, d;

    pte_kind_e        kind;
    logic [PPN_W-1:0] next_ppn;
    logic [PPN_W-1:0] leaf_ppn;

    ptw_addr_gen #(
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W),
        .LVL_W   (LVL_W),
        .PG_SHIFT(PG_SHIFT)
    ) i_addr_gen (
        .short_fmt_i(q.short_fmt),
        .level_i    (q.level),
        .vpn_i      (q.vpn),
        .table_ppn_i(q.table_ppn),
        .addr_o     (mem_addr_o)
    );

    ptw_pte_eval #(
        .PPN_W (PPN_W),
        .DATA_W(DATA_W),
        .LVL_W (LVL_W)
    ) i_pte_eval (
        .pte_i      (mem_rsp_data_i),
        .short_fmt_i(q.short_fmt),
        .level_i    (q.level),
        .vpn_low_i  (q.vpn[PPN_W-1:0]),
        .store_i    (q.store),
        .kind_o     (kind),
        .next_ppn_o (next_ppn),
        .leaf_ppn_o (leaf_ppn)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.vpn       = req_vpn_i;
                    d.store     = req_store_i;
                    d.table_ppn = root_ppn_i;
                    d.res_ppn   = '0;
                    d.res_flags = '0;
                    d.pf        = 1'b0;
                    d.af        = 1'b0;
                    d.short_fmt = 1'b0;
                    d.state     = ST_MREQ;
                    unique case (mode_i)
                        MC_L2: begin
                            d.short_fmt = 1'b1;
                            d.level     = LVL_W'(1);
                        end
                        MC_L3:   d.level = LVL_W'(2);
                        MC_L4:   d.level = LVL_W'(3);
                        MC_L5:   d.level = LVL_W'(4);
                        default: begin
                            d.level = '0;
                            d.pf    = 1'b1;
                            d.state = ST_RESP;
                        end
                    endcase
                end
            end
            ST_MREQ: begin
                if (mem_req_ready_i) begin
                    d.state = ST_MWAIT;
                end
            end
            ST_MWAIT: begin
                if (mem_rsp_valid_i) begin
                    d.state = ST_RESP;
                    if (mem_rsp_err_i) begin
                        d.af = 1'b1;
                    end else begin
                        unique case (kind)
                            PTE_PTR: begin
                                if (q.level == '0) begin
                                    d.pf = 1'b1;
                                end else begin
                                    d.level     = q.level - LVL_W'(1);
                                    d.table_ppn = next_ppn;
                                    d.state     = ST_MREQ;
                                end
                            end
                            PTE_LEAF: begin
                                d.res_ppn   = leaf_ppn;
                                d.res_flags = mem_rsp_data_i[7:0];
                            end
                            default: d.pf = 1'b1;
                        endcase
                    end
                end
            end
            ST_RESP: begin
                if (rsp_ready_i) begin
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready_o        = (q.state == ST_IDLE);
    assign mem_req_valid_o    = (q.state == ST_MREQ);
    assign rsp_valid_o        = (q.state == ST_RESP);
    assign rsp_ppn_o          = q.res_ppn;
    assign rsp_flags_o        = q.res_flags;
    assign rsp_level_o        = q.level;
    assign rsp_page_fault_o   = q.pf;
    assign rsp_access_fault_o = q.af;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int PPN_W = 44,
    parameter int PA_W  = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       mode_i,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic             rsp_valid_o,
    input logic             rsp_ready_i,
    input logic [PPN_W-1:0] rsp_ppn_o,
    input logic             rsp_page_fault_o,
    input logic             rsp_access_fault_o,
    input logic             mem_req_valid_o,
    input logic             mem_req_ready_i,
    input logic [PA_W-1:0]  mem_addr_o,
    input logic             mem_rsp_valid_i,
    input logic             mem_rsp_err_i
);

    // R1: no second request is taken in the cycle after one is accepted
    a_r1_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    // R1: a pending response holds every field until taken
    a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_ppn_o)
            && $stable(rsp_page_fault_o) && $stable(rsp_access_fault_o)));

    // R2: no-translation mode faults at once without a read
    a_r2_bare_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && mode_i == 4'd0)
            |=> (rsp_valid_o && rsp_page_fault_o && !mem_req_valid_o));

    // R4: read address held while the read is stalled
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

    // R4: no read while idle
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_req_valid_o);

    // R9: a bus error on a pending read ends in an access fault
    a_r9_err_to_af: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid_i && mem_rsp_err_i && !req_ready_o && !rsp_valid_o && !mem_req_valid_o)
            |=> (rsp_valid_o && rsp_access_fault_o && !rsp_page_fault_o));

    // R9: fault kinds are exclusive
    a_r9_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !(rsp_page_fault_o && rsp_access_fault_o));

endmodule

bind pt_walker ptw_checker #(
    .PPN_W(PPN_W),
    .PA_W (PA_W)
) i_ptw_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .mode_i            (mode_i),
    .req_valid_i       (req_valid_i),
    .req_ready_o       (req_ready_o),
    .rsp_valid_o       (rsp_valid_o),
    .rsp_ready_i       (rsp_ready_i),
    .rsp_ppn_o         (rsp_ppn_o),
    .rsp_page_fault_o  (rsp_page_fault_o),
    .rsp_access_fault_o(rsp_access_fault_o),
    .mem_req_valid_o   (mem_req_valid_o),
    .mem_req_ready_i   (mem_req_ready_i),
    .mem_addr_o        (mem_addr_o),
    .mem_rsp_valid_i   (mem_rsp_valid_i),
    .mem_rsp_err_i     (mem_rsp_err_i)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

    localparam int VPN_W = 45;
    localparam int PPN_W = 44;
    localparam int DATA_W = 64;
    localparam int LVL_W = 3;
    localparam int PA_W = 56;
    localparam int NVEC = 19;

    typedef struct packed {
        logic [3:0]       mode;
        logic [PPN_W-1:0] root;
        logic [VPN_W-1:0] vpn;
        logic             st;
        logic             pf;
        logic             af;
        logic [PPN_W-1:0] ppn;
        logic [2:0]       lvl;
        logic [7:0]       flg;
        logic [3:0]       rds;
        logic [7:0]       req;
    } vec_t;

    // Flags: V=01 R=02 W=04 X=08 A=40 D=80; mode 8 = 3-level, 1 = 2-level, 9 = 4-level, 10 = 5-level
    localparam vec_t VECS [NVEC] = '{
        '{4'd8,  44'h100, 45'h40403, 1'b0, 1'b0, 1'b0, 44'h12345,     3'd0, 8'hC7, 4'd3, 8'd4},  // R4 R10 3-level walk
        '{4'd8,  44'h100, 45'h40403, 1'b1, 1'b0, 1'b0, 44'h12345,     3'd0, 8'hC7, 4'd3, 8'd8},  // R8 store, D set
        '{4'd8,  44'h100, 45'h40404, 1'b0, 1'b0, 1'b0, 44'h555,       3'd0, 8'h47, 4'd3, 8'd8},  // R8 load, D clear
        '{4'd8,  44'h100, 45'h40404, 1'b1, 1'b1, 1'b0, 44'h0,         3'd0, 8'h00, 4'd3, 8'd8},  // R8 store, D clear
        '{4'd8,  44'h100, 45'h40405, 1'b0, 1'b1, 1'b0, 44'h0,         3'd0, 8'h00, 4'd3, 8'd8},  // R8 A clear
        '{4'd8,  44'h100, 45'h40406, 1'b0, 1'b1, 1'b0, 44'h0,         3'd0, 8'h00, 4'd3, 8'd5},  // R5 V clear
        '{4'd8,  44'h100, 45'h40407, 1'b0, 1'b1, 1'b0, 44'h0,         3'd0, 8'h00, 4'd3, 8'd5},  // R5 W without R
        '{4'd8,  44'h100, 45'h40BAB, 1'b0, 1'b0, 1'b0, 44'h5AB,       3'd1, 8'hCB, 4'd2, 8'd7},  // R7 level-1 superpage
        '{4'd8,  44'h100, 45'h40C00, 1'b0, 1'b1, 1'b0, 44'h0,         3'd1, 8'h00, 4'd2, 8'd7},  // R7 misaligned
        '{4'd8,  44'h100, 45'h40408, 1'b0, 1'b1, 1'b0, 44'h0,         3'd0, 8'h00, 4'd3, 8'd6},  // R6 pointer at level 0
        '{4'd8,  44'h100, 45'h40E00, 1'b0, 1'b0, 1'b1, 44'h0,         3'd1, 8'h00, 4'd2, 8'd9},  // R9 bus error
        '{4'd8,  44'h100, 45'h92345, 1'b0, 1'b0, 1'b0, 44'h52345,     3'd2, 8'hCF, 4'd1, 8'd7},  // R7 level-2 superpage
        '{4'd1,  44'h900, 45'h00C05, 1'b0, 1'b0, 1'b0, 44'h2ABCDE,    3'd0, 8'hC7, 4'd2, 8'd3},  // R3 2-level, short entries
        '{4'd1,  44'h900, 45'h012AA, 1'b0, 1'b0, 1'b0, 44'h16AA,      3'd1, 8'hCB, 4'd1, 8'd7},  // R7 short superpage
        '{4'd1,  44'h900, 45'h01400, 1'b0, 1'b1, 1'b0, 44'h0,         3'd1, 8'h00, 4'd1, 8'd7},  // R7 short misaligned
        '{4'd9,  44'hB00, 45'h00001, 1'b0, 1'b0, 1'b0, 44'hABCDEF012, 3'd0, 8'hC7, 4'd4, 8'd3},  // R3 4-level
        '{4'd10, 44'hC00, 45'h00000, 1'b0, 1'b0, 1'b0, 44'h777,       3'd0, 8'hC3, 4'd5, 8'd3},  // R3 5-level
        '{4'd0,  44'h100, 45'h40403, 1'b0, 1'b1, 1'b0, 44'h0,         3'd0, 8'h00, 4'd0, 8'd2},  // R2 no translation
        '{4'd5,  44'h100, 45'h40403, 1'b0, 1'b1, 1'b0, 44'h0,         3'd0, 8'h00, 4'd0, 8'd2}   // R2 unknown code
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        mode_i = '0;
    logic [PPN_W-1:0]  root_ppn_i = '0;
    logic              req_valid_i = 1'b0;
    logic              req_ready_o;
    logic [VPN_W-1:0]  req_vpn_i = '0;
    logic              req_store_i = 1'b0;
    logic              rsp_valid_o;
    logic              rsp_ready_i = 1'b0;
    logic [PPN_W-1:0]  rsp_ppn_o;
    logic [7:0]        rsp_flags_o;
    logic [LVL_W-1:0]  rsp_level_o;
    logic              rsp_page_fault_o;
    logic              rsp_access_fault_o;
    logic              mem_req_valid_o;
    logic              mem_req_ready_i = 1'b0;
    logic [PA_W-1:0]   mem_addr_o;
    logic              mem_rsp_valid_i = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data_i = '0;
    logic              mem_rsp_err_i = 1'b0;

    always #4 clk = ~clk;

    pt_walker i_pt_walker (.*);

    logic [DATA_W-1:0] pmem [logic [PA_W-1:0]];
    localparam logic [PA_W-1:0] ERR_ADDR = 56'h200038;
    int reads = 0;
    int n_tests = 0;
    int n_fail = 0;

    always @(posedge clk) begin
        mem_req_ready_i <= ~mem_req_ready_i;
        mem_rsp_valid_i <= 1'b0;
        mem_rsp_err_i   <= 1'b0;
        if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
            reads = reads + 1;
            mem_rsp_valid_i <= 1'b1;
            mem_rsp_err_i   <= (mem_addr_o == ERR_ADDR);
            mem_rsp_data_i  <= pmem.exists(mem_addr_o) ? pmem[mem_addr_o] : '0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_rsp(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (rsp_valid_o) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        mode_i      = v.mode;
        root_ppn_i  = v.root;
        req_vpn_i   = v.vpn;
        req_store_i = v.st;
        req_valid_i = 1'b1;
        reads       = 0;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic check_result(input vec_t v, input int idx);
        bit ok;
        string t;
        wait_rsp(ok);
        t = $sformatf("R%0d vec%0d rsp_valid", v.req, idx);
        chk(t, 64'(ok), 64'd1);
        t = $sformatf("R%0d vec%0d page_fault", v.req, idx);
        chk(t, 64'(rsp_page_fault_o), 64'(v.pf));
        t = $sformatf("R%0d vec%0d access_fault", v.req, idx);
        chk(t, 64'(rsp_access_fault_o), 64'(v.af));
        t = $sformatf("R%0d vec%0d reads", v.req, idx);
        chk(t, 64'(reads), 64'(v.rds));
        if (!v.pf && !v.af) begin
            t = $sformatf("R%0d vec%0d ppn", v.req, idx);
            chk(t, 64'(rsp_ppn_o), 64'(v.ppn));
            t = $sformatf("R%0d vec%0d level", v.req, idx);
            chk(t, 64'(rsp_level_o), 64'(v.lvl));
            t = $sformatf("R%0d vec%0d flags", v.req, idx);
            chk(t, 64'(rsp_flags_o), 64'(v.flg));
        end
        rsp_ready_i = 1'b1;
        @(negedge clk);
        rsp_ready_i = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // 3-level tables, root 0x100
        pmem[56'h100008] = 64'h80001;
        pmem[56'h200010] = 64'hC0001;
        pmem[56'h300018] = (64'h12345 << 10) | 64'hC7;
        pmem[56'h300020] = (64'h555 << 10) | 64'h47;
        pmem[56'h300028] = (64'h666 << 10) | 64'h87;
        pmem[56'h300038] = (64'h777 << 10) | 64'hC5;
        pmem[56'h300040] = (64'h700 << 10) | 64'h01;
        pmem[56'h200028] = (64'h400 << 10) | 64'hCB;
        pmem[56'h200030] = (64'h401 << 10) | 64'hCB;
        pmem[56'h100010] = (64'h40000 << 10) | 64'hCF;
        // 2-level tables, root 0x900; upper word of short entry is junk
        pmem[56'h90000C] = (64'hA00 << 10) | 64'h01;
        pmem[56'hA00014] = 64'hFFFF_FFFF_AAF3_78C7;
        pmem[56'h900010] = (64'h1400 << 10) | 64'hCB;
        pmem[56'h900014] = (64'h1401 << 10) | 64'hCB;
        // 4-level, root 0xB00
        pmem[56'hB00000] = (64'hB01 << 10) | 64'h01;
        pmem[56'hB01000] = (64'hB02 << 10) | 64'h01;
        pmem[56'hB02000] = (64'hB03 << 10) | 64'h01;
        pmem[56'hB03008] = (64'hABCDEF012 << 10) | 64'hC7;
        // 5-level, root 0xC00
        pmem[56'hC00000] = (64'hC01 << 10) | 64'h01;
        pmem[56'hC01000] = (64'hC02 << 10) | 64'h01;
        pmem[56'hC02000] = (64'hC03 << 10) | 64'h01;
        pmem[56'hC03000] = (64'hC04 << 10) | 64'h01;
        pmem[56'hC04000] = (64'h777 << 10) | 64'hC3;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset req_ready", 64'(req_ready_o), 64'd1);
        chk("R1 reset rsp_valid", 64'(rsp_valid_o), 64'd0);
        chk("R4 reset mem_req_valid", 64'(mem_req_valid_o), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            launch(VECS[i]);
            chk($sformatf("R1 vec%0d busy after accept", i), 64'(req_ready_o), 64'd0);
            if (VECS[i].rds == 0) begin
                // R2: fault must be visible one cycle after acceptance
                chk($sformatf("R2 vec%0d immediate fault", i), 64'(rsp_valid_o), 64'd1);
            end
            check_result(VECS[i], i);
        end

        // R11: controls changed right after acceptance are ignored
        launch(VECS[0]);
        mode_i     = 4'd0;
        root_ppn_i = 44'h5;
        check_result('{4'd8, 44'h100, 45'h40403, 1'b0, 1'b0, 1'b0, 44'h12345,
                       3'd0, 8'hC7, 4'd3, 8'd11}, 100);

        // R1: response held while not taken, new request refused
        launch(VECS[7]);
        begin
            bit ok;
            wait_rsp(ok);
            req_valid_i = 1'b1;
            mode_i      = 4'd0;
            repeat (4) @(negedge clk);
            req_valid_i = 1'b0;
            chk("R1 held rsp_valid", 64'(rsp_valid_o), 64'd1);
            chk("R1 held ppn", 64'(rsp_ppn_o), 64'h5AB);
            chk("R1 held level", 64'(rsp_level_o), 64'd1);
            chk("R1 busy while held", 64'(req_ready_o), 64'd0);
            rsp_ready_i = 1'b1;
            @(negedge clk);
            rsp_ready_i = 1'b0;
            chk("R1 idle after take", 64'(req_ready_o), 64'd1);
            chk("R1 no response after take", 64'(rsp_valid_o), 64'd0);
        end

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule